// File: doc/BRIEF.md
# Shadowed Lockable Nonvolatile Memory Slice

This block is a byte-addressed storage slice. It holds two 16-byte nonvolatile blocks and one 16-byte plain SRAM. Each nonvolatile block sits behind a shadow RAM. Every host read and write goes to the shadow copy, so the nonvolatile store changes only when a copy command commits a whole block. A recall command reloads a shadow from the store. A lock command makes a block permanently read-only. The store is modelled as a register array, and the programming delay is a parameterised cycle count.

The host uses one address/data/strobe port for byte accesses. It also has three command strobes (copy, recall, lock) that share one command address; that address selects the 16-byte block the command acts on. A status byte reports:
- a copy-busy bit,
- a host-writable lock-arm bit,
- one lock flag per block.

When block 1 is recalled, the slice emits a one-cycle strobe carrying stored bytes 0x30 and 0x31. A neighbouring control block uses these to reload its default settings.

Top module: `nvshadow_mem`

## Requirements
- R1: After synchronous reset, every shadow, stored and SRAM byte, the status byte and `rd_data` are all zero, and both blocks are unlocked.
- R2: Address map: block 0 shadow is 0x20-0x2F, block 1 shadow is 0x30-0x3F, SRAM is 0x80-0x8F and the status byte is at 0x07. Reads are registered: `rd_data` shows the byte at `addr` one clock later. Any other address reads 0 and ignores writes.
- R3: A write to an unlocked block that is not busy updates only its shadow byte. The stored copy is unchanged until a copy command.
- R4: A copy command whose address lies in an unlocked block, issued while not busy, sets status bit 7 for exactly COPY_CYCLES cycles. The block's shadow is committed to the store at the final busy clock edge. A copy whose address is locked or outside both blocks does nothing.
- R5: While busy, writes to 0x20-0x3F and all three commands are ignored. SRAM and status writes still take effect.
- R6: A recall command loads the addressed block's shadow from its stored copy, whether or not the block is locked.
- R7: Status bit 6 (arm) is the only host-writable status bit. Bits 7, 5:2 and 1:0 ignore writes.
- R8: A lock command takes effect only when arm is 1 and its address lies in a block. It then sets that block's flag (status bit 0 for block 0, bit 1 for block 1) and clears arm. Once a block is locked, writes to it and copies of it are ignored. A flag is never cleared except by reset.
- R9: One cycle after a recall of block 1, `reload_vld` is high for one cycle, with `reload_lo`/`reload_hi` equal to the stored bytes at 0x30/0x31. A recall of block 0 leaves `reload_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for host read and write |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Registered read byte for `addr` |
| cmd_copy | input | 1 | Copy shadow to store for block at `cmd_addr` |
| cmd_recall | input | 1 | Reload shadow from store for block at `cmd_addr` |
| cmd_lock | input | 1 | Lock block at `cmd_addr` (needs arm) |
| cmd_addr | input | 8 | Address selecting the command's block |
| reload_vld | output | 1 | One-cycle strobe after a recall of block 1 |
| reload_lo | output | 8 | Stored byte at 0x30 |
| reload_hi | output | 8 | Stored byte at 0x31 |

## Verification
The hardest situation to reach is proving what the store holds: it is invisible at the ports until a recall copies it back into a shadow. The stimulus therefore first overwrites a shadow with a value that differs from the stored one, then recalls the block. This shows both that committed data survived and that uncommitted data, including data written to a block that was later locked, never reached the store. A second hard case is the busy window. Writes, a lock command and an arm write are issued inside it, and the status byte is read before and after it ends.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int NUM_BLK    = 2;
    localparam int BLK_BYTES  = 16;
    localparam int OFF_W      = $clog2(BLK_BYTES);
    localparam int BLK_W      = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam int RSV_W      = 6 - NUM_BLK;
    localparam int RELOAD_BLK = 1;

    typedef enum logic [1:0] {RG_RSVD, RG_NV, RG_SRAM, RG_STAT} region_e;

    typedef struct packed {
        region_e          rg;
        logic [BLK_W-1:0] blk;
        logic [OFF_W-1:0] off;
    } dec_t;

    typedef struct packed {
        logic               busy;
        logic               arm;
        logic [RSV_W-1:0]   rsv;
        logic [NUM_BLK-1:0] lk;
    } stat_t;

    // Bases must be aligned to BLK_BYTES.
    function automatic dec_t decode(input logic [7:0] a, input logic [7:0] nv_base,
                                    input logic [7:0] sram_base, input logic [7:0] stat_addr);
        dec_t d;
        logic [7:0] rel_nv;
        logic [7:0] rel_sr;
        rel_nv = a - nv_base;
        rel_sr = a - sram_base;
        d.rg   = RG_RSVD;
        d.blk  = '0;
        d.off  = a[OFF_W-1:0];
        if (a == stat_addr) begin
            d.rg = RG_STAT;
        end else if (rel_nv < 8'(NUM_BLK * BLK_BYTES)) begin
            d.rg  = RG_NV;
            d.blk = rel_nv[OFF_W +: BLK_W];
        end else if (rel_sr < 8'(BLK_BYTES)) begin
            d.rg = RG_SRAM;
        end
        return d;
    endfunction
endpackage

// File: rtl/nvm_bank.sv
module nvm_bank import nvm_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic             recall,
    input  logic             lock_set,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_byte,
    output logic             locked,
    output logic [15:0]      head
);
    logic [7:0] shadow [BLK_BYTES];
    logic [7:0] store  [BLK_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLK_BYTES; i++) begin
                shadow[i] <= '0;
                store[i]  <= '0;
            end
            locked <= 1'b0;
        end else begin
            if (lock_set) locked <= 1'b1;
            if (recall) begin
                for (int i = 0; i < BLK_BYTES; i++) shadow[i] <= store[i];
            end else if (wr_en && !locked) begin
                shadow[wr_off] <= wr_data;
            end
            if (commit && !locked) begin
                for (int i = 0; i < BLK_BYTES; i++) store[i] <= shadow[i];
            end
        end
    end

    assign rd_byte = shadow[rd_off];
    assign head    = {store[1], store[0]};
endmodule

// File: rtl/nvm_sram.sv
module nvm_sram import nvm_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_byte
);
    logic [7:0] mem [BLK_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLK_BYTES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[off] <= wr_data;
        end
    end

    assign rd_byte = mem[off];
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl import nvm_pkg::*; #(
    parameter int COPY_CYCLES = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_copy,
    input  logic               cmd_recall,
    input  logic               cmd_lock,
    input  logic               cmd_hit,
    input  logic [BLK_W-1:0]   cmd_blk,
    input  logic [NUM_BLK-1:0] locks,
    input  logic               arm_wr,
    input  logic               arm_val,
    output logic               busy,
    output logic               arm,
    output logic [NUM_BLK-1:0] commit,
    output logic [NUM_BLK-1:0] recall,
    output logic [NUM_BLK-1:0] lock_set
);
    localparam int CNT_W = $clog2(COPY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic [BLK_W-1:0] tgt;
    logic idle_ok, do_copy, do_recall, do_lock, last;

    always_comb begin
        idle_ok   = !busy && cmd_hit;
        do_copy   = idle_ok && cmd_copy && !locks[cmd_blk];
        do_recall = idle_ok && !cmd_copy && cmd_recall;
        do_lock   = idle_ok && !cmd_copy && !cmd_recall && cmd_lock && arm;
        last      = busy && (cnt == CNT_W'(COPY_CYCLES - 1));
        commit    = '0;
        recall    = '0;
        lock_set  = '0;
        if (last)      commit[tgt]       = 1'b1;
        if (do_recall) recall[cmd_blk]   = 1'b1;
        if (do_lock)   lock_set[cmd_blk] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            arm  <= 1'b0;
            cnt  <= '0;
            tgt  <= '0;
        end else begin
            if (do_copy) begin
                busy <= 1'b1;
                cnt  <= '0;
                tgt  <= cmd_blk;
            end else if (last) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
            if (do_lock)     arm <= 1'b0;
            else if (arm_wr) arm <= arm_val;
        end
    end
endmodule

// File: rtl/nvshadow_mem.sv
module nvshadow_mem import nvm_pkg::*; #(
    parameter logic [7:0] NV_BASE     = 8'h20,
    parameter logic [7:0] SRAM_BASE   = 8'h80,
    parameter logic [7:0] STAT_ADDR   = 8'h07,
    parameter int         COPY_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cmd_copy,
    input  logic       cmd_recall,
    input  logic       cmd_lock,
    input  logic [7:0] cmd_addr,
    output logic       reload_vld,
    output logic [7:0] reload_lo,
    output logic [7:0] reload_hi
);
    dec_t hd, cd;
    logic unused_cmd_off;
    logic busy, arm;
    logic [NUM_BLK-1:0] locks, commit, recall_v, lock_set;
    logic [7:0]  bank_rd [NUM_BLK];
    logic [15:0] head    [NUM_BLK];
    logic [7:0]  sram_rd, rd_next;
    stat_t       stat;

    assign hd = decode(addr, NV_BASE, SRAM_BASE, STAT_ADDR);
    assign cd = decode(cmd_addr, NV_BASE, SRAM_BASE, STAT_ADDR);
    assign unused_cmd_off = ^cd.off;

    nvm_ctrl #(.COPY_CYCLES(COPY_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_copy(cmd_copy), .cmd_recall(cmd_recall), .cmd_lock(cmd_lock),
        .cmd_hit(cd.rg == RG_NV), .cmd_blk(cd.blk), .locks(locks),
        .arm_wr(wr_en && hd.rg == RG_STAT), .arm_val(wr_data[6]),
        .busy(busy), .arm(arm), .commit(commit), .recall(recall_v), .lock_set(lock_set)
    );

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_bank
        nvm_bank u_bank (
            .clk(clk), .rst(rst),
            .wr_en(wr_en && !busy && hd.rg == RG_NV && hd.blk == BLK_W'(b)),
            .wr_off(hd.off), .wr_data(wr_data),
            .commit(commit[b]), .recall(recall_v[b]), .lock_set(lock_set[b]),
            .rd_off(hd.off), .rd_byte(bank_rd[b]),
            .locked(locks[b]), .head(head[b])
        );
    end

    nvm_sram u_sram (
        .clk(clk), .rst(rst),
        .wr_en(wr_en && hd.rg == RG_SRAM),
        .off(hd.off), .wr_data(wr_data), .rd_byte(sram_rd)
    );

    always_comb begin
        stat = '{busy: busy, arm: arm, rsv: '0, lk: locks};
        unique case (hd.rg)
            RG_NV:   rd_next = bank_rd[hd.blk];
            RG_SRAM: rd_next = sram_rd;
            RG_STAT: rd_next = stat;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            reload_vld <= 1'b0;
            reload_lo  <= '0;
            reload_hi  <= '0;
        end else begin
            rd_data    <= rd_next;
            reload_vld <= recall_v[RELOAD_BLK];
            if (recall_v[RELOAD_BLK]) begin
                reload_lo <= head[cd.blk][7:0];
                reload_hi <= head[cd.blk][15:8];
            end
        end
    end
endmodule

// File: rtl/nvm_chk.sv
module nvm_chk import nvm_pkg::*; (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               arm,
    input logic               cmd_copy,
    input logic [NUM_BLK-1:0] locks,
    input logic [NUM_BLK-1:0] commit
);
    // R8
    lock_oneway_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(locks) & ~locks) == '0);
    // R8
    lock_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (locks != $past(locks)) |-> ($past(arm) && !arm));
    // R8
    lock_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(locks ^ $past(locks)) <= 1);
    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_copy));
    // R4
    commit_end_chk: assert property (@(posedge clk) disable iff (rst)
        (commit != '0) |=> !busy);
    // R4
    commit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit) && ((commit == '0) || busy));
endmodule

bind nvshadow_mem nvm_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .arm(arm),
    .cmd_copy(cmd_copy), .locks(locks), .commit(commit)
);

// File: tb/sim_nvshadow_mem.sv
module sim_nvshadow_mem;
    localparam int CC = 40;

    logic clk = 0, rst = 1;
    logic [7:0] addr, wr_data, cmd_addr, rd_data, reload_lo, reload_hi;
    logic wr_en, cmd_copy, cmd_recall, cmd_lock, reload_vld;

    nvshadow_mem #(.COPY_CYCLES(CC)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cmd_copy(cmd_copy), .cmd_recall(cmd_recall),
        .cmd_lock(cmd_lock), .cmd_addr(cmd_addr), .reload_vld(reload_vld),
        .reload_lo(reload_lo), .reload_hi(reload_hi)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        int         cyc;
    } rd_item_t;

    rd_item_t q[$];
    int cyc = 0, total = 0, fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // monitor: pops expected reads once the registered result is out
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc < cyc) begin
            rd_item_t it;
            it = q.pop_front();
            check(it.tag, rd_data, it.exp);
        end
    end

    function automatic void clear();
        addr = 0; wr_en = 0; wr_data = 0;
        cmd_copy = 0; cmd_recall = 0; cmd_lock = 0; cmd_addr = 0;
    endfunction

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); clear(); end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); clear(); addr = a; wr_en = 1; wr_data = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); clear(); addr = a;
        q.push_back('{e, tag, cyc});
    endtask

    task automatic cmd(input string kind, input logic [7:0] a);
        @(negedge clk); clear(); cmd_addr = a;
        if (kind == "copy")        cmd_copy = 1;
        else if (kind == "recall") cmd_recall = 1;
        else                       cmd_lock = 1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        clear();
        repeat (3) @(negedge clk);
        rst = 0;
        rd(8'h07, 8'h00, "R1 status after reset");
        rd(8'h20, 8'h00, "R1 shadow after reset");
        rd(8'h8F, 8'h00, "R1 sram after reset");

        wr(8'h20, 8'hA5); wr(8'h2F, 8'h5A); wr(8'h35, 8'h11);
        wr(8'h80, 8'hC3); wr(8'h8F, 8'h3C);
        wr(8'h50, 8'hFF); wr(8'h1F, 8'hEE); wr(8'h40, 8'hDD);
        rd(8'h20, 8'hA5, "R3 shadow write blk0 low");
        rd(8'h2F, 8'h5A, "R2 blk0 top byte");
        rd(8'h35, 8'h11, "R2 blk1 byte");
        rd(8'h80, 8'hC3, "R2 sram low");
        rd(8'h8F, 8'h3C, "R2 sram top");
        rd(8'h50, 8'h00, "R2 reserved 0x50");
        rd(8'h1F, 8'h00, "R2 reserved 0x1F");
        rd(8'h40, 8'h00, "R2 reserved 0x40");

        cmd("recall", 8'h27);
        @(negedge clk); clear();
        check("R9 no reload on blk0 recall", {7'd0, reload_vld}, 8'h00);
        rd(8'h20, 8'h00, "R3 store untouched by write");
        rd(8'h2F, 8'h00, "R6 recall blk0 top");

        wr(8'h20, 8'hA5); wr(8'h2F, 8'h5A);
        cmd("copy", 8'h2A);
        rd(8'h07, 8'h80, "R4 busy set");
        wr(8'h21, 8'h99);
        wr(8'h81, 8'h44);
        wr(8'h07, 8'h40);
        cmd("lock", 8'h20);
        rd(8'h21, 8'h00, "R5 nv write ignored while busy");
        rd(8'h81, 8'h44, "R5 sram write while busy");
        rd(8'h07, 8'hC0, "R5 arm write while busy, lock ignored");
        idle(CC + 5);
        rd(8'h07, 8'h40, "R4 busy cleared");
        wr(8'h07, 8'h00);
        rd(8'h07, 8'h00, "R7 arm cleared by host");

        wr(8'h20, 8'h00);
        cmd("recall", 8'h20);
        rd(8'h20, 8'hA5, "R4 committed byte recalled");
        rd(8'h2F, 8'h5A, "R6 committed top recalled");

        cmd("recall", 8'h3F);
        @(negedge clk); clear();
        check("R9 reload strobe", {7'd0, reload_vld}, 8'h01);
        check("R9 reload lo blank", reload_lo, 8'h00);
        rd(8'h35, 8'h00, "R6 blk1 never copied");

        cmd("copy", 8'h50);
        rd(8'h07, 8'h00, "R4 copy of reserved ignored");

        cmd("lock", 8'h20);
        rd(8'h07, 8'h00, "R8 lock without arm ignored");
        wr(8'h22, 8'h12);
        rd(8'h22, 8'h12, "R8 blk0 still writable");

        wr(8'h07, 8'hFF);
        rd(8'h07, 8'h40, "R7 only arm writable");
        cmd("lock", 8'h2C);
        rd(8'h07, 8'h01, "R8 blk0 locked, arm cleared");
        wr(8'h20, 8'hFF);
        rd(8'h20, 8'hA5, "R8 write to locked ignored");
        cmd("copy", 8'h20);
        rd(8'h07, 8'h01, "R8 copy of locked ignored");
        cmd("recall", 8'h20);
        rd(8'h22, 8'h00, "R6 recall of locked block");
        cmd("lock", 8'h30);
        rd(8'h07, 8'h01, "R8 second lock needs re-arm");

        wr(8'h30, 8'hE1); wr(8'h31, 8'h1E);
        cmd("copy", 8'h3F);
        idle(CC + 5);
        wr(8'h30, 8'h00);
        cmd("recall", 8'h31);
        @(negedge clk); clear();
        check("R9 reload strobe blk1", {7'd0, reload_vld}, 8'h01);
        check("R9 reload lo", reload_lo, 8'hE1);
        check("R9 reload hi", reload_hi, 8'h1E);
        @(negedge clk); clear();
        check("R9 strobe one cycle", {7'd0, reload_vld}, 8'h00);
        rd(8'h30, 8'hE1, "R6 blk1 recall");

        wr(8'h07, 8'h40);
        cmd("lock", 8'h3A);
        rd(8'h07, 8'h03, "R8 both locked");
        wr(8'h07, 8'h00);
        rd(8'h07, 8'h03, "R8 flags stay set");
        idle(4);
        summary();
    end
endmodule